// File: doc/BRIEF.md
# Staged Read Control and Status Register

This block is the control and status word for the staged (indirect) read path of a serial-flash controller. It also holds the small sequencer that tracks which staged reads are pending and which one is active. Software writes the word to launch or abort reads. The block hands each accepted read to the flash engine as a job, using the start address and byte count that other registers already hold. Software reads the same word back to see whether reads are outstanding, whether the job slots are full, how many reads have finished, and whether the data buffer ever stalled.

There are two job slots, and the block counts them without storing anything per job: every job uses the same pre-programmed transfer settings, so the slots differ only in order. Jobs go to the engine one at a time over a valid/ready handshake. A completion pulse from the engine retires the active job. A cancel empties both slots and raises an abort strobe toward the engine. The done flag and the buffer-full flag are sticky, and software clears each one by writing 1 to it.

Top module: `sread_csr`

## Requirements
- R1: After reset the word reads 0x00000000. Bits 31:8 always read 0. A read at any offset other than REG_OFFSET (default 0x60) returns 0, and a write there has no effect.
- R2: A write with bit 0 set, while fewer than two reads are outstanding, adds one read. Bit 2 reads 1 whenever at least one read is pending or active.
- R3: Bit 4 reads 1 when two reads are outstanding. A start write at that point is dropped silently, and no further job is issued for it.
- R4: `job_valid` is high only while a read is pending and none is active. A job is taken on a cycle where `job_valid` and `job_ready` are both high, and `job_valid` then stays low until `job_done` retires that job.
- R5: A `job_done` pulse while a job is active sets bit 5 and adds one to the count in bits 7:6. The count saturates at 3.
- R6: Writing 1 to bit 5 clears bit 5 and the count. If a completion arrives in the same cycle, the result is bit 5 set with a count of 1.
- R7: A `buf_full` pulse sets bit 3, which holds until software writes 1 to bit 3. A new event in the same cycle as that clear wins, and bit 3 stays set.
- R8: A write with bit 1 set empties both slots at the next edge and pulses `job_abort` high for one cycle. A start bit in the same write is ignored, and a `job_done` for an aborted job is not counted.
- R9: Bits 0 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| job_valid | output | 1 | A read job is offered to the engine |
| job_ready | input | 1 | The engine accepts the offered job |
| job_done | input | 1 | Completion pulse for the active job |
| buf_full | input | 1 | Buffer-full stall event from the engine |
| job_abort | output | 1 | Abort strobe to the engine |

## Verification
A wrong slot count shows up at the ports within one cycle, in three ways: bit 2 or bit 4 reads wrongly, `job_valid` rises while a job is active, or a dropped third start comes back as an extra job after the first two retire. A wrong completion counter or a flag that clears itself shows in bits 7:3 on the next read after the offending edge. The bench reads the word after every stimulus cycle. Each stimulus vector holds two things: a sequence of starts, handshakes, completions, stalls and clears, and the status that the requirements predict after each step. Cancel is exercised mid-queue, together with a start in the same write, and ahead of a late completion.

// File: rtl/sread_pkg.sv
package sread_pkg;
   // Field positions inside the status word; the layout is software-visible.
   localparam int unsigned START_BIT  = 0;
   localparam int unsigned CANCEL_BIT = 1;
   localparam int unsigned BUSY_BIT   = 2;
   localparam int unsigned FULL_BIT   = 3;
   localparam int unsigned PAIR_BIT   = 4;
   localparam int unsigned DONE_BIT   = 5;
   localparam int unsigned CNT_LSB    = 6;
   localparam int unsigned CNT_W      = 2;
   localparam int unsigned FIELD_W    = CNT_LSB + CNT_W;

   typedef struct packed {
      logic [CNT_W-1:0] done_cnt;
      logic             done_flag;
      logic             pair_busy;
      logic             full_flag;
      logic             busy;
      logic             cancel_rd;
      logic             start_rd;
   } stat_t;
endpackage

// File: rtl/sread_decode.sv
module sread_decode #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 'h60
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              hit,
   output logic              start_req,
   output logic              cancel_req,
   output logic              clr_done,
   output logic              clr_full
);
   import sread_pkg::*;

   logic wr_hit;

   assign hit        = (bus_addr == REG_OFFSET);
   assign wr_hit     = bus_wr && hit;
   assign start_req  = wr_hit && bus_wdata[START_BIT];
   assign cancel_req = wr_hit && bus_wdata[CANCEL_BIT];
   assign clr_done   = wr_hit && bus_wdata[DONE_BIT];
   assign clr_full   = wr_hit && bus_wdata[FULL_BIT];
endmodule

// File: rtl/sread_queue.sv
module sread_queue #(
   parameter int unsigned DEPTH     = 2,
   parameter bit          ABORT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic cancel_req,
   input  logic job_ready,
   input  logic job_done,
   output logic job_valid,
   output logic job_abort,
   output logic retire,
   output logic busy,
   output logic pair_busy
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0] pend_q;
   logic          act_q;
   logic [CW:0]   outs;
   logic          issue;
   logic          accept;

   assign job_valid = (pend_q != '0) && !act_q;
   assign issue     = job_valid && job_ready;
   assign retire    = act_q && job_done && !cancel_req;
   assign outs      = {1'b0, pend_q} + (CW+1)'(act_q);
   assign accept    = start_req && !cancel_req && (outs < (CW+1)'(DEPTH));
   assign busy      = (outs != '0);
   assign pair_busy = (outs == (CW+1)'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= 1'b0;
      end else if (cancel_req) begin
         pend_q <= '0;
         act_q  <= 1'b0;
      end else begin
         pend_q <= pend_q + CW'(accept) - CW'(issue);
         act_q  <= (act_q && !retire) || issue;
      end
   end

   generate
      if (ABORT_REG) begin : g_abort_reg
         logic abort_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) abort_q <= 1'b0;
            else        abort_q <= cancel_req;
         end
         assign job_abort = abort_q;
      end else begin : g_abort_comb
         assign job_abort = cancel_req;
      end
   endgenerate
endmodule

// File: rtl/sread_status.sv
module sread_status
   import sread_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire,
   input  logic             full_evt,
   input  logic             clr_done,
   input  logic             clr_full,
   output logic             done_flag,
   output logic             full_flag,
   output logic [CNT_W-1:0] done_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_base;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_base = clr_done ? '0 : done_cnt;
      cnt_nxt  = cnt_base;
      if (retire && (cnt_base != CNT_MAX)) cnt_nxt = cnt_base + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_flag <= 1'b0;
         full_flag <= 1'b0;
         done_cnt  <= '0;
      end else begin
         done_flag <= retire || (done_flag && !clr_done);
         full_flag <= full_evt || (full_flag && !clr_full);
         done_cnt  <= cnt_nxt;
      end
   end
endmodule

// File: rtl/sread_csr.sv
module sread_csr #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 'h60,
   parameter int unsigned QUEUE_DEPTH = 2,
   parameter bit          ABORT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              job_valid,
   input  logic              job_ready,
   input  logic              job_done,
   input  logic              buf_full,
   output logic              job_abort
);
   import sread_pkg::*;

   generate
      if (DATA_W < FIELD_W) begin : g_bad_width
         $error("sread_csr: DATA_W must hold the status fields");
      end
      if (QUEUE_DEPTH < 1) begin : g_bad_depth
         $error("sread_csr: QUEUE_DEPTH must be at least 1");
      end
   endgenerate

   logic  hit, start_req, cancel_req, clr_done, clr_full;
   logic  retire, busy, pair_busy;
   logic  done_flag, full_flag;
   logic [CNT_W-1:0] done_cnt;
   stat_t stat;
   logic [FIELD_W-1:0] stat_byte;

   sread_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)) u_decode (
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .hit(hit), .start_req(start_req), .cancel_req(cancel_req),
      .clr_done(clr_done), .clr_full(clr_full)
   );

   sread_queue #(.DEPTH(QUEUE_DEPTH), .ABORT_REG(ABORT_REG)) u_queue (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .cancel_req(cancel_req),
      .job_ready(job_ready), .job_done(job_done), .job_valid(job_valid),
      .job_abort(job_abort), .retire(retire), .busy(busy), .pair_busy(pair_busy)
   );

   sread_status u_status (
      .clk(clk), .rst_n(rst_n), .retire(retire), .full_evt(buf_full),
      .clr_done(clr_done), .clr_full(clr_full),
      .done_flag(done_flag), .full_flag(full_flag), .done_cnt(done_cnt)
   );

   always_comb begin
      stat           = '0;
      stat.busy      = busy;
      stat.full_flag = full_flag;
      stat.pair_busy = pair_busy;
      stat.done_flag = done_flag;
      stat.done_cnt  = done_cnt;
   end

   assign stat_byte = stat;
   assign bus_rdata = hit ? DATA_W'(stat_byte) : '0;
endmodule

// File: rtl/sread_csr_chk.sv
module sread_csr_chk #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 'h60,
   parameter bit          ABORT_REG  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              job_valid,
   input logic              job_ready,
   input logic              job_abort,
   input logic [7:0]        stat
);
   logic cancel_wr, clr_done_wr, clr_full_wr;
   assign cancel_wr   = bus_wr && (bus_addr == REG_OFFSET) && bus_wdata[1];
   assign clr_done_wr = bus_wr && (bus_addr == REG_OFFSET) && bus_wdata[5];
   assign clr_full_wr = bus_wr && (bus_addr == REG_OFFSET) && bus_wdata[3];

   p_valid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (job_valid && !job_ready && !cancel_wr) |=> job_valid);

   p_pair_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stat[4] |-> stat[2]);

   p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[7:6] == 2'd3 && !clr_done_wr && !cancel_wr) |=> (stat[7:6] == 2'd3));

   p_cnt_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[7:6] != 2'd0) |-> stat[5]);

   p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[3] && !clr_full_wr) |=> stat[3]);

   p_ctrl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[2]) |-> (stat[1:0] == 2'b00));

   generate
      if (ABORT_REG) begin : g_reg
         p_abort_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            job_abort |-> $past(cancel_wr));
         p_abort_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
            job_abort |-> (!job_valid && !stat[2]));
      end else begin : g_comb
         p_abort_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            job_abort |-> cancel_wr);
      end
   endgenerate
endmodule

bind sread_csr sread_csr_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET), .ABORT_REG(ABORT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .job_valid(job_valid), .job_ready(job_ready),
   .job_abort(job_abort), .stat(stat_byte)
);

// File: tb/sread_csr_bench.sv
module sread_csr_bench;
   localparam int CYC = 8;   // 125 MHz
   localparam logic [7:0] OFS = 8'h60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = OFS;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        job_valid, job_abort;
   logic        job_ready = 1'b0, job_done = 1'b0, buf_full = 1'b0;

   int checks = 0;
   int errors = 0;

   always #(CYC/2) clk = ~clk;

   sread_csr u_sread_csr (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .job_valid(job_valid),
      .job_ready(job_ready), .job_done(job_done), .buf_full(buf_full),
      .job_abort(job_abort)
   );

   typedef struct packed {
      logic       wr;
      logic       hit;
      logic [7:0] wd;
      logic       rdy;
      logic       dn;
      logic       fl;
      logic [7:0] exp;
      logic       ev;
      logic       ea;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 28;
   // wr hit wdata rdy done full | status valid abort | requirement
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b1,8'h00,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd1}, // R1 idle
      '{1'b1,1'b1,8'h01,1'b0,1'b0,1'b0, 8'h04,1'b1,1'b0, 4'd2}, // R2 first start
      '{1'b1,1'b1,8'h01,1'b0,1'b0,1'b0, 8'h14,1'b1,1'b0, 4'd3}, // R3 second start
      '{1'b1,1'b1,8'h01,1'b0,1'b0,1'b0, 8'h14,1'b1,1'b0, 4'd3}, // R3 third dropped
      '{1'b0,1'b1,8'h00,1'b1,1'b0,1'b0, 8'h14,1'b0,1'b0, 4'd4}, // R4 handshake
      '{1'b0,1'b1,8'h00,1'b0,1'b1,1'b0, 8'h64,1'b1,1'b0, 4'd5}, // R5 first done
      '{1'b0,1'b1,8'h00,1'b1,1'b0,1'b0, 8'h64,1'b0,1'b0, 4'd4}, // R4 second job
      '{1'b0,1'b1,8'h00,1'b0,1'b1,1'b0, 8'hA0,1'b0,1'b0, 4'd5}, // R5 count 2, idle
      '{1'b0,1'b1,8'h00,1'b0,1'b0,1'b1, 8'hA8,1'b0,1'b0, 4'd7}, // R7 stall sets
      '{1'b1,1'b1,8'h08,1'b0,1'b0,1'b0, 8'hA0,1'b0,1'b0, 4'd7}, // R7 clear
      '{1'b1,1'b1,8'h01,1'b0,1'b0,1'b0, 8'hA4,1'b1,1'b0, 4'd9}, // R9 ctrl bits 0
      '{1'b0,1'b1,8'h00,1'b1,1'b0,1'b0, 8'hA4,1'b0,1'b0, 4'd4},
      '{1'b0,1'b1,8'h00,1'b0,1'b1,1'b0, 8'hE0,1'b0,1'b0, 4'd5}, // R5 count 3
      '{1'b1,1'b1,8'h01,1'b0,1'b0,1'b0, 8'hE4,1'b1,1'b0, 4'd2},
      '{1'b0,1'b1,8'h00,1'b1,1'b0,1'b0, 8'hE4,1'b0,1'b0, 4'd4},
      '{1'b0,1'b1,8'h00,1'b0,1'b1,1'b0, 8'hE0,1'b0,1'b0, 4'd5}, // R5 saturates
      '{1'b1,1'b1,8'h20,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd6}, // R6 clear
      '{1'b1,1'b1,8'h01,1'b0,1'b0,1'b0, 8'h04,1'b1,1'b0, 4'd2},
      '{1'b1,1'b1,8'h01,1'b0,1'b0,1'b0, 8'h14,1'b1,1'b0, 4'd3},
      '{1'b0,1'b1,8'h00,1'b1,1'b0,1'b0, 8'h14,1'b0,1'b0, 4'd4},
      '{1'b1,1'b1,8'h02,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b1, 4'd8}, // R8 cancel
      '{1'b0,1'b1,8'h00,1'b0,1'b1,1'b0, 8'h00,1'b0,1'b0, 4'd8}, // R8 late done
      '{1'b1,1'b0,8'h01,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd1}, // R1 other offset
      '{1'b1,1'b1,8'h03,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b1, 4'd8}, // R8 start+cancel
      '{1'b1,1'b1,8'h01,1'b0,1'b0,1'b0, 8'h04,1'b1,1'b0, 4'd2},
      '{1'b0,1'b1,8'h00,1'b1,1'b0,1'b0, 8'h04,1'b0,1'b0, 4'd4},
      '{1'b1,1'b1,8'h20,1'b0,1'b1,1'b0, 8'h60,1'b0,1'b0, 4'd6}, // R6 done wins
      '{1'b1,1'b1,8'h08,1'b0,1'b0,1'b1, 8'h68,1'b0,1'b0, 4'd7}  // R7 set wins
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_read();
      bus_wr = 1'b0; bus_wdata = '0; job_ready = 1'b0; job_done = 1'b0;
      buf_full = 1'b0; bus_addr = OFS;
      #1;
   endtask

   initial begin
      #(CYC * 100000);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      idle_read();
      check("R1 reset word", bus_rdata, 32'h0);
      check("R1 reset valid", {31'b0, job_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         bus_wr    = VEC[i].wr;
         bus_addr  = VEC[i].hit ? OFS : 8'h44;
         bus_wdata = {24'h0, VEC[i].wd};
         job_ready = VEC[i].rdy;
         job_done  = VEC[i].dn;
         buf_full  = VEC[i].fl;
         @(posedge clk);
         @(negedge clk);
         idle_read();
         check($sformatf("R%0d status step %0d", VEC[i].req, i), bus_rdata, {24'h0, VEC[i].exp});
         check($sformatf("R%0d valid step %0d", VEC[i].req, i), {31'b0, job_valid}, {31'b0, VEC[i].ev});
         check($sformatf("R%0d abort step %0d", VEC[i].req, i), {31'b0, job_abort}, {31'b0, VEC[i].ea});
      end
      // R1: other offset reads zero while flags are set
      bus_addr = 8'h64;
      #1;
      check("R1 other offset read", bus_rdata, 32'h0);
      bus_addr = OFS;
      #1;
      check("R1 flags still held", bus_rdata, 32'h68);
      // R1: reset mid-run returns everything to zero
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset mid-run", bus_rdata, 32'h0);
      // R3: after a dropped third start, only two jobs are ever offered
      bus_wr = 1'b1; bus_wdata = 32'h1;
      repeat (3) @(negedge clk);
      idle_read();
      for (int j = 0; j < 2; j++) begin
         job_ready = 1'b1;
         @(negedge clk);
         job_ready = 1'b0; job_done = 1'b1;
         @(negedge clk);
         job_done = 1'b0;
      end
      #1;
      check("R3 no third job", {31'b0, job_valid}, 32'h0);
      check("R3 count two", bus_rdata, 32'hA0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule